// File: doc/BRIEF.md
# Page Write Collector with In-Page Wraparound

This block sits behind a two-wire serial memory slave engine and gathers the data bytes of one write transaction into a page-sized latch. The engine hands over a word address when a write begins, then one strobe per received data byte, then a strobe when the bus STOP arrives. Each byte goes to the latch slot picked by the low address bits. Those bits advance after every byte and wrap inside the page. The upper address bits select the page row and never change during a transaction.

On STOP, if at least one byte was latched and the write-protect pin is low, the block opens a timed write window and raises `busy_o`. While the window is open, the serial engine is expected to refuse the bus. During the window the block scans the page slots in ascending order and drives the memory write port only for slots that the transaction filled. A STOP with no data, or a STOP while write-protect is high, discards the latch and opens no window. All traffic from the engine is ignored while the window is open.

Top module: `page_commit_buffer`

## Requirements
- R1: After reset, `busy_o` and `mem_we_o` are low.
- R2: A start strobe loads `start_addr_i`. The page row is bits [12:5] and the slot is bits [4:0]. Each accepted data byte is stored at the current slot, and then only the slot advances by one. During the commit, every write uses the address {page row, slot} and carries the last byte stored in that slot.
- R3: After slot 31 the next byte goes to slot 0 of the same page row.
- R4: When more than 32 bytes arrive in one transaction, a later byte replaces the earlier byte in the same slot, and only the latest value is committed.
- R5: A STOP after at least one data byte, with `wp_i` low, raises `busy_o` at the next clock edge. `busy_o` then stays high for exactly WRITE_CYCLES clocks, or PAGE_BYTES clocks if that is larger.
- R6: During a commit, `mem_we_o` pulses once for each slot written in that transaction and for no other slot. It is never high outside the busy window.
- R7: A STOP with no data byte since the start strobe raises neither `busy_o` nor `mem_we_o`.
- R8: A STOP while `wp_i` is high raises neither `busy_o` nor `mem_we_o`, and it discards the latched bytes, so a later transaction does not commit them.
- R9: `mem_we_o` is low in every clock where `wp_i` is high. A slot whose commit cycle falls in such a clock is not written.
- R10: While `busy_o` is high, start, byte and STOP strobes have no effect. No byte is latched, the address is not reloaded, and no further commit follows.
- R11: The slot at offset k is written in the k-th clock of the busy window, counting from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | A new write transaction begins; load the address |
| start_addr_i | input | 13 | Word address of the first data byte |
| byte_vld_i | input | 1 | One data byte is present on `byte_i` |
| byte_i | input | 8 | Data byte |
| stop_i | input | 1 | The transaction has ended with STOP |
| wp_i | input | 1 | Write protect; high blocks every array write |
| busy_o | output | 1 | Timed write window is open; the engine must NACK |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | 13 | Array write address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
The bench covers several transaction shapes: a short run in the middle of a page, a run that crosses slot 31 and must land back at slot 0 of the same row, and a run of 40 bytes. The first shows plain slot advance and address formation. The second separates in-page wrap from a carry into the row bits. The third separates overwriting from appending. Further cases are an address-only STOP and a STOP with write-protect high, both of which must open no window. A commit is also run with write-protect pulsed in the middle, which must drop exactly the slots whose cycles it covers. Another commit has strobes injected into the busy window, and these must leave no trace afterwards.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
    localparam int unsigned PCB_ADDR_W = 13;
    localparam int unsigned PCB_DATA_W = 8;
    localparam int unsigned PCB_PAGE_BYTES = 32;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_phase_e;
endpackage

// File: rtl/pcb_pointer.sv
module pcb_pointer #(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned OFF_W  = 5
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     load_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic                     adv_i,
    input  logic                     close_i,
    output logic                     open_o,
    output logic [ADDR_W-OFF_W-1:0]  page_o,
    output logic [OFF_W-1:0]         off_o
);
    localparam int unsigned PAGE_W = ADDR_W - OFF_W;

    typedef struct packed {
        logic              open;
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  off;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load_i) begin
            ptr_d.open = 1'b1;
            ptr_d.page = addr_i[ADDR_W-1:OFF_W];
            ptr_d.off  = addr_i[OFF_W-1:0];
        end else begin
            if (adv_i) begin
                ptr_d.off = ptr_q.off + OFF_W'(1);
            end
            if (close_i) begin
                ptr_d.open = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign open_o = ptr_q.open;
    assign page_o = ptr_q.page;
    assign off_o  = ptr_q.off;

    // R3
    slot_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && !load_i) |=> (off_o == OFF_W'($past(off_o) + 1'b1)));

    // R2
    row_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && !load_i) |=> $stable(page_o));
endmodule

// File: rtl/pcb_latch.sv
module pcb_latch #(
    parameter int unsigned PAGE_BYTES = 32,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned OFF_W      = 5
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  clr_i,
    input  logic                  wr_i,
    input  logic [OFF_W-1:0]      wr_off_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    input  logic [OFF_W-1:0]      rd_off_i,
    output logic [DATA_W-1:0]     rd_data_o,
    output logic [PAGE_BYTES-1:0] mask_o,
    output logic                  any_o
);
    typedef struct packed {
        logic [PAGE_BYTES-1:0][DATA_W-1:0] bytes;
        logic [PAGE_BYTES-1:0]             mask;
    } latch_t;

    latch_t lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (clr_i) begin
            lat_d.mask = '0;
        end else if (wr_i) begin
            lat_d.bytes[wr_off_i] = wr_data_i;
            lat_d.mask[wr_off_i]  = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign rd_data_o = lat_q.bytes[rd_off_i];
    assign mask_o    = lat_q.mask;
    assign any_o     = |lat_q.mask;

    // R8
    mask_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (mask_o == '0));

    // R2
    slot_marked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !clr_i) |=> mask_o[$past(wr_off_i)]);
endmodule

// File: rtl/pcb_sequencer.sv
module pcb_sequencer
    import pcb_pkg::*;
#(
    parameter int unsigned PAGE_BYTES = 32,
    parameter int unsigned OFF_W      = 5,
    parameter int unsigned CYC        = 64
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  go_i,
    input  logic [PAGE_BYTES-1:0] mask_i,
    input  logic                  wp_i,
    output logic                  busy_o,
    output logic                  we_o,
    output logic [OFF_W-1:0]      scan_off_o,
    output logic                  done_o
);
    localparam int unsigned CNT_W = $clog2(CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC - 1);
    localparam logic [CNT_W-1:0] SCAN_END = CNT_W'(PAGE_BYTES);

    typedef struct packed {
        seq_phase_e       phase;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic scan_active;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.phase)
            SEQ_IDLE: begin
                if (go_i) begin
                    seq_d.phase = SEQ_RUN;
                    seq_d.cnt   = '0;
                end
            end
            SEQ_RUN: begin
                if (seq_q.cnt == LAST) begin
                    seq_d.phase = SEQ_IDLE;
                    seq_d.cnt   = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + CNT_W'(1);
                end
            end
            default: seq_d = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seq_q <= '{phase: SEQ_IDLE, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o      = (seq_q.phase == SEQ_RUN);
    assign scan_active = busy_o && (seq_q.cnt < SCAN_END);
    assign scan_off_o  = seq_q.cnt[OFF_W-1:0];
    assign we_o        = scan_active && mask_i[scan_off_o] && !wp_i;
    assign done_o      = busy_o && (seq_q.cnt == LAST);

    // R5
    window_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !done_o) |=> busy_o);

    // R5
    window_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !busy_o);
endmodule

// File: rtl/page_commit_buffer.sv
module page_commit_buffer
    import pcb_pkg::*;
#(
    parameter int unsigned ADDR_W       = PCB_ADDR_W,
    parameter int unsigned DATA_W       = PCB_DATA_W,
    parameter int unsigned PAGE_BYTES   = PCB_PAGE_BYTES,
    parameter int unsigned WRITE_CYCLES = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              stop_i,
    input  logic              wp_i,
    output logic              busy_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o
);
    localparam int unsigned OFF_W  = $clog2(PAGE_BYTES);
    localparam int unsigned PAGE_W = ADDR_W - OFF_W;
    localparam int unsigned CYC    = (WRITE_CYCLES > PAGE_BYTES) ? WRITE_CYCLES : PAGE_BYTES;

    logic                  load, adv, close, go, clr, seq_done;
    logic                  tr_open, any_byte;
    logic [PAGE_W-1:0]     page;
    logic [OFF_W-1:0]      wr_off, scan_off;
    logic [PAGE_BYTES-1:0] mask;

    assign load  = start_i && !busy_o;
    assign adv   = byte_vld_i && !busy_o && tr_open && !load;
    assign close = stop_i && !busy_o && !load;
    assign go    = close && tr_open && any_byte && !wp_i;
    assign clr   = load || (close && !go) || seq_done;

    pcb_pointer #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) i_pointer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (load),
        .addr_i  (start_addr_i),
        .adv_i   (adv),
        .close_i (close),
        .open_o  (tr_open),
        .page_o  (page),
        .off_o   (wr_off)
    );

    pcb_latch #(
        .PAGE_BYTES (PAGE_BYTES),
        .DATA_W     (DATA_W),
        .OFF_W      (OFF_W)
    ) i_latch (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (clr),
        .wr_i      (adv),
        .wr_off_i  (wr_off),
        .wr_data_i (byte_i),
        .rd_off_i  (scan_off),
        .rd_data_o (mem_wdata_o),
        .mask_o    (mask),
        .any_o     (any_byte)
    );

    pcb_sequencer #(
        .PAGE_BYTES (PAGE_BYTES),
        .OFF_W      (OFF_W),
        .CYC        (CYC)
    ) i_sequencer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .go_i       (go),
        .mask_i     (mask),
        .wp_i       (wp_i),
        .busy_o     (busy_o),
        .we_o       (mem_we_o),
        .scan_off_o (scan_off),
        .done_o     (seq_done)
    );

    assign mem_addr_o = {page, scan_off};

    // R5
    commit_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_i && !start_i && !busy_o && tr_open && any_byte && !wp_i) |=> busy_o);

    // R7
    empty_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_i && !busy_o && !any_byte) |=> !busy_o);

    // R8
    wp_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_i && !busy_o && wp_i) |=> !busy_o);

    // R9
    wp_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wp_i |-> !mem_we_o);

    // R6
    we_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |-> busy_o);

    // R10
    frozen_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o)) |-> $stable(page));
endmodule

// File: tb/test_page_commit_buffer.sv
`timescale 1ns/1ps
module test_page_commit_buffer;
    localparam int unsigned AW  = 13;
    localparam int unsigned DW  = 8;
    localparam int unsigned WC  = 40;
    localparam int unsigned CYC = 40;

    typedef struct {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        int            cyc;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] start_addr_i = '0;
    logic          byte_vld_i = 1'b0;
    logic [DW-1:0] byte_i = '0;
    logic          stop_i = 1'b0;
    logic          wp_i = 1'b0;
    logic          busy_o, mem_we_o;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_wdata_o;

    int checks = 0;
    int errors = 0;
    int bidx = 0;
    item_t exp_q[$];

    logic [7:0]    m_page;
    logic [4:0]    m_off;
    logic          m_open = 1'b0;
    logic [31:0]   m_mask = '0;
    logic [DW-1:0] m_data[32];

    always #4 clk = ~clk;

    page_commit_buffer #(.WRITE_CYCLES(WC)) i_page_commit_buffer (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .byte_vld_i(byte_vld_i), .byte_i(byte_i), .stop_i(stop_i), .wp_i(wp_i),
        .busy_o(busy_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every array write
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we_o) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected write addr", int'(mem_addr_o), -1);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk(mem_addr_o == it.addr, "R2 write address", int'(mem_addr_o), int'(it.addr));
                    chk(mem_wdata_o == it.data, "R4 write data", int'(mem_wdata_o), int'(it.data));
                    chk(bidx == it.cyc, "R11 write cycle", bidx, it.cyc);
                end
            end
            if (busy_o) bidx++;
            else bidx = 0;
        end
    end

    task automatic clear_in();
        start_i = 1'b0; byte_vld_i = 1'b0; stop_i = 1'b0;
    endtask

    task automatic do_start(input logic [AW-1:0] a);
        start_i = 1'b1; start_addr_i = a;
        @(posedge clk); #1; clear_in();
        m_open = 1'b1; m_page = a[12:5]; m_off = a[4:0]; m_mask = '0;
    endtask

    task automatic do_byte(input logic [DW-1:0] d);
        byte_vld_i = 1'b1; byte_i = d;
        @(posedge clk); #1; clear_in();
        m_data[m_off] = d; m_mask[m_off] = 1'b1; m_off = m_off + 5'd1;
    endtask

    // STOP, then follow the busy window; wp high for busy cycles lo..hi; junk strobes inside window
    task automatic do_stop(input int lo, input int hi, input bit junk, input string tag);
        bit commit;
        int n;
        int k;
        commit = m_open && (m_mask != 0) && !wp_i;
        if (commit) begin
            for (int o = 0; o < 32; o++) begin
                if (m_mask[o] && !(o >= lo && o <= hi)) begin
                    item_t it;
                    it.addr = {m_page, 5'(o)};
                    it.data = m_data[o];
                    it.cyc  = o;
                    exp_q.push_back(it);
                end
            end
        end
        stop_i = 1'b1;
        @(posedge clk); #1; clear_in();
        m_open = 1'b0; m_mask = '0;
        n = 0; k = 0;
        forever begin
            wp_i = (k >= lo && k <= hi);
            if (junk) begin
                start_i = (k == 3); start_addr_i = 13'h1FE0;
                byte_vld_i = (k == 4); byte_i = 8'hEE;
                stop_i = (k == 5);
            end
            @(negedge clk);
            if (!busy_o) break;
            n++;
            @(posedge clk); #1; k++;
        end
        clear_in(); wp_i = 1'b0;
        @(posedge clk); #1;
        chk(n == (commit ? CYC : 0), tag, n, commit ? CYC : 0);
        chk(exp_q.size() == 0, "R6 pending writes", exp_q.size(), 0);
    endtask

    task automatic idle_check(input int cycles, input string tag);
        int seen;
        seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (busy_o || mem_we_o) seen++;
            @(posedge clk); #1;
        end
        chk(seen == 0, tag, seen, 0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(busy_o == 1'b0, "R1 busy after reset", int'(busy_o), 0);
        chk(mem_we_o == 1'b0, "R1 we after reset", int'(mem_we_o), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R2 R5 R11: short run mid-page
        do_start(13'h0105);
        for (int i = 0; i < 4; i++) do_byte(8'h10 + 8'(i));
        do_stop(-1, -2, 1'b0, "R5 busy length");

        // R3: run crossing slot 31
        do_start(13'h03FE);
        for (int i = 0; i < 5; i++) do_byte(8'hA0 + 8'(i));
        do_stop(-1, -2, 1'b0, "R3 wrap commit length");

        // R4: 40 bytes overwrite slots 0..7
        do_start(13'h0A40);
        for (int i = 0; i < 40; i++) do_byte(8'(i * 3 + 1));
        do_stop(-1, -2, 1'b0, "R4 overwrite commit length");

        // R7: address-only write
        do_start(13'h0200);
        do_stop(-1, -2, 1'b0, "R7 empty stop");

        // R8: write-protect at STOP, then a new transaction must not carry old bytes
        do_start(13'h0300);
        for (int i = 0; i < 3; i++) do_byte(8'h55);
        wp_i = 1'b1;
        do_stop(-1, -2, 1'b0, "R8 protected stop");
        do_start(13'h0420);
        do_byte(8'h77);
        do_stop(-1, -2, 1'b0, "R8 follow-up commit");

        // R9: wp pulse inside window drops slots 2..4
        do_start(13'h0600);
        for (int i = 0; i < 6; i++) do_byte(8'hC0 + 8'(i));
        do_stop(2, 4, 1'b0, "R9 window length");

        // R10: strobes during busy are ignored
        do_start(13'h0700);
        do_byte(8'h99);
        do_stop(-1, -2, 1'b1, "R10 window length");
        idle_check(5, "R10 no second window");
        m_open = 1'b0;
        do_stop(-1, -2, 1'b0, "R10 bare stop");
        do_start(13'h0020);
        do_stop(-1, -2, 1'b0, "R10 no stale byte");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule